// File: doc/BRIEF.md
# Segment Selector Table Lookup Unit

This block keeps the base address and the limit of three descriptor tables (global, local, interrupt) and turns a 16-bit segment selector into the linear address of the 8-byte descriptor it names. For each request it checks that the entire descriptor sits inside the selected table's limit. It also works out the effective privilege level of the access and flags a privilege violation. Fetching the descriptor from memory is left to the caller.

A separate table-register port writes a new base and limit into one table, or reads the current pair back. A write is refused unless the current privilege level is 0. A refused write leaves the register unchanged and raises a one-cycle protection fault. This port is run by a small state register. Its state records what the port did on the previous cycle:
- `ACC_IDLE`: nothing.
- `ACC_WROTE`: a write was accepted.
- `ACC_READ`: a read-back was accepted.
- `ACC_REFUSED`: a write was refused.

On every clock the port makes one of four transitions:
- take-write: a write at level 0 to an existing table, goes to `ACC_WROTE`.
- refuse-write: a write at any other level, goes to `ACC_REFUSED`.
- take-read: a read-back with no write in the same cycle, goes to `ACC_READ`.
- rest: no operation, or a write to the reserved table code, goes to `ACC_IDLE`.

The port outputs are decoded from the state alone.

Top module: `seg_table_xlate`

## Requirements
- R1: A write (`tr_load`) at `cpl` = 0 stores `tr_base_in`/`tr_limit_in` into the table chosen by `tr_tbl`. A read-back (`tr_store`) raises `tr_rd_valid` one clock later, together with that table's base and limit.
- R2: A write while `cpl` is not 0 leaves every table unchanged. One clock later `prot_fault` is 1 for exactly one cycle, and `tr_rd_valid` stays 0.
- R3: One clock after `req_valid`, `rsp_valid` is 1. `rsp_addr` then equals base + `req_sel[15:3]`*8, taken modulo 2^32.
- R4: `rsp_limit_fault` is 1 when `req_sel[15:3]`*8+7 is greater than the selected table's 16-bit limit, and 0 otherwise.
- R5: Table codes, on both ports, are 00 global, 01 local and 10 interrupt. Code 11 on a request gives `rsp_limit_fault` = 1 and `rsp_addr` = 0. A read-back of code 11 returns base 0 and limit 0.
- R6: `rsp_epl` is the numerically larger of the requestor level `req_sel[1:0]` and the descriptor level `req_ar[6:5]`.
- R7: `rsp_priv_fault` is 1 when `rsp_epl` is greater than the descriptor level, or when `cpl` is greater than the descriptor level.
- R8: A synchronous reset clears every base and limit to 0 and drives every output to 0.
- R9: A write takes priority over a read-back in the same cycle, and that read-back is dropped. A write with code 11 changes nothing and raises no fault. A request in the same cycle as a write sees the table value from before the write.
- R10: With `req_valid` low, `rsp_valid` is 0 on the next cycle and the other response outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpl | input | 2 | Current privilege level |
| tr_load | input | 1 | Write base/limit into a table register |
| tr_store | input | 1 | Read a table register back |
| tr_tbl | input | 2 | Table code for the register port |
| tr_base_in | input | 32 | Base address to write |
| tr_limit_in | input | 16 | Limit to write |
| tr_rd_valid | output | 1 | Read-back data valid |
| tr_rd_base | output | 32 | Read-back base |
| tr_rd_limit | output | 16 | Read-back limit |
| prot_fault | output | 1 | One-cycle pulse for a refused write |
| req_valid | input | 1 | Selector request valid |
| req_sel | input | 16 | Segment selector |
| req_tbl | input | 2 | Table code for the request |
| req_ar | input | 8 | Descriptor access-rights byte |
| rsp_valid | output | 1 | Response valid |
| rsp_addr | output | 32 | Linear address of the descriptor |
| rsp_limit_fault | output | 1 | Descriptor outside the table limit, or reserved table |
| rsp_priv_fault | output | 1 | Privilege check failed |
| rsp_epl | output | 2 | Effective privilege level |

## Verification
A corrupted table register never shows directly. It becomes visible on the next request to that table, as a wrong `rsp_addr` or a wrong `rsp_limit_fault`, or on the next read-back, one clock after the request. The bench therefore reads every table back after each write, refused write and reserved-code write. A stuck or mis-coded access-port state shows up within one cycle, as a `prot_fault` or `tr_rd_valid` that lasts too long or never comes. The vector walk mixes tables, limit edges and privilege combinations, so a swapped table code or a wrong compare edge changes a response field on the very next cycle.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int TSEL_W  = 2;
    localparam int PRIV_W  = 2;
    localparam int DPL_LSB = 5;

    typedef enum logic [TSEL_W-1:0] {
        TBL_GLOBAL = 2'b00,
        TBL_LOCAL  = 2'b01,
        TBL_INTR   = 2'b10,
        TBL_RSVD   = 2'b11
    } tbl_sel_e;

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_WROTE   = 2'd1,
        ACC_READ    = 2'd2,
        ACC_REFUSED = 2'd3
    } acc_state_e;

    function automatic logic [PRIV_W-1:0] priv_weaker(
        input logic [PRIV_W-1:0] a,
        input logic [PRIV_W-1:0] b
    );
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_tbl_bank.sv
module seg_tbl_bank
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LIM_W   = 16,
    parameter int NUM_TBL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [TSEL_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [LIM_W-1:0]  wr_limit,
    input  logic [TSEL_W-1:0] rq_idx,
    output logic [ADDR_W-1:0] rq_base,
    output logic [LIM_W-1:0]  rq_limit,
    output logic              rq_hit,
    input  logic [TSEL_W-1:0] st_idx,
    output logic [ADDR_W-1:0] st_base,
    output logic [LIM_W-1:0]  st_limit
);

    logic [ADDR_W-1:0] base_q  [NUM_TBL];
    logic [LIM_W-1:0]  limit_q [NUM_TBL];
    logic [NUM_TBL-1:0] rq_match;
    logic [NUM_TBL-1:0] st_match;
    logic [NUM_TBL-1:0] wr_match;

    // one decode line per table for each access path
    for (genvar g = 0; g < NUM_TBL; g++) begin : g_dec
        assign rq_match[g] = (rq_idx == TSEL_W'(g));
        assign st_match[g] = (st_idx == TSEL_W'(g));
        assign wr_match[g] = wr_en && (wr_idx == TSEL_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NUM_TBL; t++) begin
                base_q[t]  <= '0;
                limit_q[t] <= '0;
            end
        end else begin
            for (int t = 0; t < NUM_TBL; t++) begin
                if (wr_match[t]) begin
                    base_q[t]  <= wr_base;
                    limit_q[t] <= wr_limit;
                end
            end
        end
    end

    always_comb begin
        rq_base  = '0;
        rq_limit = '0;
        rq_hit   = 1'b0;
        st_base  = '0;
        st_limit = '0;
        for (int t = 0; t < NUM_TBL; t++) begin
            if (rq_match[t]) begin
                rq_base  = base_q[t];
                rq_limit = limit_q[t];
                rq_hit   = 1'b1;
            end
            if (st_match[t]) begin
                st_base  = base_q[t];
                st_limit = limit_q[t];
            end
        end
    end

endmodule

// File: rtl/seg_desc_locate.sv
module seg_desc_locate #(
    parameter int ADDR_W    = 32,
    parameter int LIM_W     = 16,
    parameter int SEL_W     = 16,
    parameter int DESC_LOG2 = 3
) (
    input  logic [SEL_W-1:DESC_LOG2] sel_index,
    input  logic [ADDR_W-1:0]        base,
    input  logic [LIM_W-1:0]         limit,
    input  logic                     hit,
    output logic [ADDR_W-1:0]        desc_addr,
    output logic                     lim_fault
);

    localparam int IDX_W = SEL_W - DESC_LOG2;
    localparam int CMP_W = ((SEL_W > LIM_W) ? SEL_W : LIM_W) + 1;
    localparam int LAST  = (1 << DESC_LOG2) - 1;

    logic [IDX_W-1:0] idx;
    logic [SEL_W-1:0] ofs;
    logic [CMP_W-1:0] last_byte;
    logic             over;

    assign idx       = sel_index;
    assign ofs       = {idx, {DESC_LOG2{1'b0}}};
    assign last_byte = CMP_W'(ofs) + CMP_W'(LAST);
    assign over      = last_byte > CMP_W'(limit);

    always_comb begin
        if (hit) begin
            desc_addr = base + ADDR_W'(ofs);
            lim_fault = over;
        end else begin
            desc_addr = '0;
            lim_fault = 1'b1;
        end
    end

endmodule

// File: rtl/seg_priv_eval.sv
module seg_priv_eval
    import seg_xlate_pkg::*;
(
    input  logic [PRIV_W-1:0] rpl,
    input  logic [PRIV_W-1:0] dpl,
    input  logic [PRIV_W-1:0] cur,
    output logic [PRIV_W-1:0] epl,
    output logic              deny
);

    logic weaker_req;
    logic weaker_cur;

    assign epl        = priv_weaker(rpl, dpl);
    assign weaker_req = epl > dpl;
    assign weaker_cur = cur > dpl;
    assign deny       = weaker_req || weaker_cur;

endmodule

// File: rtl/seg_table_xlate.sv
module seg_table_xlate
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LIM_W     = 16,
    parameter int SEL_W     = 16,
    parameter int NUM_TBL   = 3,
    parameter int DESC_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cpl,
    input  logic              tr_load,
    input  logic              tr_store,
    input  logic [1:0]        tr_tbl,
    input  logic [ADDR_W-1:0] tr_base_in,
    input  logic [LIM_W-1:0]  tr_limit_in,
    output logic              tr_rd_valid,
    output logic [ADDR_W-1:0] tr_rd_base,
    output logic [LIM_W-1:0]  tr_rd_limit,
    output logic              prot_fault,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [1:0]        req_tbl,
    input  logic [7:0]        req_ar,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_limit_fault,
    output logic              rsp_priv_fault,
    output logic [1:0]        rsp_epl
);

    acc_state_e state_q, state_d;

    logic              top_priv;
    logic              tbl_exists;
    logic              wr_en;
    logic              rd_take;
    logic [ADDR_W-1:0] rq_base, st_base;
    logic [LIM_W-1:0]  rq_limit, st_limit;
    logic              rq_hit;
    logic [ADDR_W-1:0] loc_addr;
    logic              loc_fault;
    logic [PRIV_W-1:0] pe_epl;
    logic              pe_deny;
    logic [ADDR_W-1:0] rd_base_q;
    logic [LIM_W-1:0]  rd_limit_q;

    assign top_priv   = (cpl == '0);
    assign tbl_exists = (tbl_sel_e'(tr_tbl) != TBL_RSVD);
    assign wr_en      = (state_d == ACC_WROTE);
    assign rd_take    = (state_d == ACC_READ);

    // access port: next state
    always_comb begin
        state_d = ACC_IDLE;
        if (tr_load) begin
            if (!top_priv)       state_d = ACC_REFUSED;
            else if (tbl_exists) state_d = ACC_WROTE;
            else                 state_d = ACC_IDLE;
        end else if (tr_store) begin
            state_d = ACC_READ;
        end
    end

    // access port: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ACC_IDLE;
        else     state_q <= state_d;
    end

    // access port: outputs decoded from the state
    always_comb begin
        prot_fault  = 1'b0;
        tr_rd_valid = 1'b0;
        unique case (state_q)
            ACC_IDLE:    ;
            ACC_WROTE:   ;
            ACC_READ:    tr_rd_valid = 1'b1;
            ACC_REFUSED: prot_fault  = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_base_q  <= '0;
            rd_limit_q <= '0;
        end else if (rd_take) begin
            rd_base_q  <= st_base;
            rd_limit_q <= st_limit;
        end
    end

    assign tr_rd_base  = rd_base_q;
    assign tr_rd_limit = rd_limit_q;

    seg_tbl_bank #(
        .ADDR_W  (ADDR_W),
        .LIM_W   (LIM_W),
        .NUM_TBL (NUM_TBL)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (tr_tbl),
        .wr_base  (tr_base_in),
        .wr_limit (tr_limit_in),
        .rq_idx   (req_tbl),
        .rq_base  (rq_base),
        .rq_limit (rq_limit),
        .rq_hit   (rq_hit),
        .st_idx   (tr_tbl),
        .st_base  (st_base),
        .st_limit (st_limit)
    );

    seg_desc_locate #(
        .ADDR_W    (ADDR_W),
        .LIM_W     (LIM_W),
        .SEL_W     (SEL_W),
        .DESC_LOG2 (DESC_LOG2)
    ) u_locate (
        .sel_index (req_sel[SEL_W-1:DESC_LOG2]),
        .base      (rq_base),
        .limit     (rq_limit),
        .hit       (rq_hit),
        .desc_addr (loc_addr),
        .lim_fault (loc_fault)
    );

    seg_priv_eval u_priv (
        .rpl  (req_sel[PRIV_W-1:0]),
        .dpl  (req_ar[DPL_LSB +: PRIV_W]),
        .cur  (cpl),
        .epl  (pe_epl),
        .deny (pe_deny)
    );

    // response register: one clock after a valid request
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid       <= 1'b0;
            rsp_addr        <= '0;
            rsp_limit_fault <= 1'b0;
            rsp_priv_fault  <= 1'b0;
            rsp_epl         <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_addr        <= loc_addr;
                rsp_limit_fault <= loc_fault;
                rsp_priv_fault  <= pe_deny;
                rsp_epl         <= pe_epl;
            end
        end
    end

endmodule

// File: rtl/seg_table_xlate_chk.sv
module seg_table_xlate_chk #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cpl,
    input logic              tr_load,
    input logic              tr_store,
    input logic              tr_rd_valid,
    input logic              prot_fault,
    input logic              req_valid,
    input logic [SEL_W-1:0]  req_sel,
    input logic [1:0]        req_tbl,
    input logic [7:0]        req_ar,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_limit_fault,
    input logic              rsp_priv_fault,
    input logic [1:0]        rsp_epl
);

    assert_refuse_cause_R2: assert property (@(posedge clk) disable iff (rst)
        prot_fault |-> ($past(tr_load) && ($past(cpl) != 2'd0)));

    assert_refuse_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (tr_load && cpl != 2'd0) |=> (prot_fault && !tr_rd_valid));

    assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
        (tr_store && !tr_load) |=> tr_rd_valid);

    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        tr_load |=> !tr_rd_valid);

    assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_rsvd_table_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_tbl == 2'b11) |=> (rsp_limit_fault && rsp_addr == '0));

    assert_epl_max_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ((rsp_epl >= $past(req_ar[6:5])) && (rsp_epl >= $past(req_sel[1:0]))
                       && ((rsp_epl == $past(req_ar[6:5])) || (rsp_epl == $past(req_sel[1:0])))));

    assert_cur_priv_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cpl > req_ar[6:5]) |=> rsp_priv_fault);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && $stable(rsp_addr) && $stable(rsp_epl)));

endmodule

bind seg_table_xlate seg_table_xlate_chk #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cpl             (cpl),
    .tr_load         (tr_load),
    .tr_store        (tr_store),
    .tr_rd_valid     (tr_rd_valid),
    .prot_fault      (prot_fault),
    .req_valid       (req_valid),
    .req_sel         (req_sel),
    .req_tbl         (req_tbl),
    .req_ar          (req_ar),
    .rsp_valid       (rsp_valid),
    .rsp_addr        (rsp_addr),
    .rsp_limit_fault (rsp_limit_fault),
    .rsp_priv_fault  (rsp_priv_fault),
    .rsp_epl         (rsp_epl)
);

// File: tb/seg_table_xlate_bench.sv
module seg_table_xlate_bench;

    typedef struct packed {
        logic [1:0]  tbl;
        logic [15:0] sel;
        logic [7:0]  ar;
        logic [1:0]  cp;
        logic [31:0] addr;
        logic        lf;
        logic        pf;
        logic [1:0]  epl;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{tbl:2'd0, sel:16'h0008, ar:8'h92, cp:2'd0, addr:32'h0001_0008, lf:1'b0, pf:1'b0, epl:2'd0},
        '{tbl:2'd0, sel:16'h00F8, ar:8'hF2, cp:2'd0, addr:32'h0001_00F8, lf:1'b0, pf:1'b0, epl:2'd3},
        '{tbl:2'd0, sel:16'h0100, ar:8'h92, cp:2'd0, addr:32'h0001_0100, lf:1'b1, pf:1'b0, epl:2'd0},
        '{tbl:2'd1, sel:16'h0013, ar:8'hB2, cp:2'd0, addr:32'h0000_0000, lf:1'b0, pf:1'b1, epl:2'd3},
        '{tbl:2'd1, sel:16'hFFF9, ar:8'hD2, cp:2'd0, addr:32'h0000_FFE8, lf:1'b0, pf:1'b0, epl:2'd2},
        '{tbl:2'd2, sel:16'h07F8, ar:8'h92, cp:2'd2, addr:32'h0000_87F8, lf:1'b0, pf:1'b1, epl:2'd0},
        '{tbl:2'd3, sel:16'h0008, ar:8'h92, cp:2'd0, addr:32'h0000_0000, lf:1'b1, pf:1'b0, epl:2'd0},
        '{tbl:2'd2, sel:16'h0802, ar:8'hF2, cp:2'd3, addr:32'h0000_8800, lf:1'b1, pf:1'b0, epl:2'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cpl = '0;
    logic        tr_load = 1'b0, tr_store = 1'b0;
    logic [1:0]  tr_tbl = '0;
    logic [31:0] tr_base_in = '0;
    logic [15:0] tr_limit_in = '0;
    logic        tr_rd_valid, prot_fault;
    logic [31:0] tr_rd_base;
    logic [15:0] tr_rd_limit;
    logic        req_valid = 1'b0;
    logic [15:0] req_sel = '0;
    logic [1:0]  req_tbl = '0;
    logic [7:0]  req_ar = '0;
    logic        rsp_valid, rsp_limit_fault, rsp_priv_fault;
    logic [31:0] rsp_addr;
    logic [1:0]  rsp_epl;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg_table_xlate u_seg_table_xlate (
        .clk (clk), .rst (rst), .cpl (cpl),
        .tr_load (tr_load), .tr_store (tr_store), .tr_tbl (tr_tbl),
        .tr_base_in (tr_base_in), .tr_limit_in (tr_limit_in),
        .tr_rd_valid (tr_rd_valid), .tr_rd_base (tr_rd_base),
        .tr_rd_limit (tr_rd_limit), .prot_fault (prot_fault),
        .req_valid (req_valid), .req_sel (req_sel), .req_tbl (req_tbl),
        .req_ar (req_ar), .rsp_valid (rsp_valid), .rsp_addr (rsp_addr),
        .rsp_limit_fault (rsp_limit_fault), .rsp_priv_fault (rsp_priv_fault),
        .rsp_epl (rsp_epl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [1:0] t, input logic [31:0] b,
                           input logic [15:0] l, input logic [1:0] c);
        @(negedge clk);
        tr_load = 1'b1; tr_tbl = t; tr_base_in = b; tr_limit_in = l; cpl = c;
        @(negedge clk);
        tr_load = 1'b0; cpl = 2'd0;
    endtask

    task automatic read_back(input string req, input logic [1:0] t,
                             input logic [31:0] eb, input logic [15:0] el);
        @(negedge clk);
        tr_store = 1'b1; tr_tbl = t;
        @(negedge clk);
        tr_store = 1'b0;
        check({req, " rd_valid"}, 32'(tr_rd_valid), 32'd1);
        check({req, " base"}, tr_rd_base, eb);
        check({req, " limit"}, 32'(tr_rd_limit), 32'(el));
    endtask

    task automatic request(input logic [1:0] t, input logic [15:0] s,
                           input logic [7:0] a, input logic [1:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_tbl = t; req_sel = s; req_ar = a; cpl = c;
        @(negedge clk);
        req_valid = 1'b0; cpl = 2'd0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: outputs cleared after reset, tables empty
        check("R8 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R8 rsp_addr", rsp_addr, 32'd0);
        check("R8 prot_fault", 32'(prot_fault), 32'd0);
        check("R8 rd_valid", 32'(tr_rd_valid), 32'd0);
        read_back("R8 global", 2'd0, 32'd0, 16'd0);
        read_back("R8 interrupt", 2'd2, 32'd0, 16'd0);

        // R1: privileged writes then read-back
        do_load(2'd0, 32'h0001_0000, 16'h00FF, 2'd0);
        check("R1 no fault", 32'(prot_fault), 32'd0);
        do_load(2'd1, 32'hFFFF_FFF0, 16'hFFFF, 2'd0);
        do_load(2'd2, 32'h0000_8000, 16'h07FF, 2'd0);
        read_back("R1 global", 2'd0, 32'h0001_0000, 16'h00FF);
        read_back("R1 local", 2'd1, 32'hFFFF_FFF0, 16'hFFFF);
        read_back("R1 interrupt", 2'd2, 32'h0000_8000, 16'h07FF);

        // R2: refused write, single-cycle pulse, table unchanged
        do_load(2'd0, 32'hDEAD_0000, 16'h1234, 2'd2);
        check("R2 fault pulse", 32'(prot_fault), 32'd1);
        check("R2 no rd_valid", 32'(tr_rd_valid), 32'd0);
        @(negedge clk);
        check("R2 pulse ends", 32'(prot_fault), 32'd0);
        read_back("R2 unchanged", 2'd0, 32'h0001_0000, 16'h00FF);

        // R9: reserved-code write ignored without fault
        do_load(2'd3, 32'h5555_5555, 16'h5555, 2'd0);
        check("R9 rsvd no fault", 32'(prot_fault), 32'd0);
        read_back("R9 global intact", 2'd0, 32'h0001_0000, 16'h00FF);
        read_back("R5 rsvd readback", 2'd3, 32'd0, 16'd0);

        // R9: write and read-back in one cycle, write wins
        @(negedge clk);
        tr_load = 1'b1; tr_store = 1'b1; tr_tbl = 2'd2;
        tr_base_in = 32'h0000_9000; tr_limit_in = 16'h0FFF;
        @(negedge clk);
        tr_load = 1'b0; tr_store = 1'b0;
        check("R9 store dropped", 32'(tr_rd_valid), 32'd0);
        read_back("R9 write taken", 2'd2, 32'h0000_9000, 16'h0FFF);
        do_load(2'd2, 32'h0000_8000, 16'h07FF, 2'd0);

        // R3 R4 R5 R6 R7: vector walk
        for (int i = 0; i < NVEC; i++) begin
            request(VECS[i].tbl, VECS[i].sel, VECS[i].ar, VECS[i].cp);
            check($sformatf("R3 valid v%0d", i), 32'(rsp_valid), 32'd1);
            check($sformatf("R3 addr v%0d", i), rsp_addr, VECS[i].addr);
            check($sformatf("R4 limit v%0d", i), 32'(rsp_limit_fault), 32'(VECS[i].lf));
            check($sformatf("R7 priv v%0d", i), 32'(rsp_priv_fault), 32'(VECS[i].pf));
            check($sformatf("R6 epl v%0d", i), 32'(rsp_epl), 32'(VECS[i].epl));
        end

        // R10: idle cycle keeps fields, drops valid
        @(negedge clk);
        check("R10 valid low", 32'(rsp_valid), 32'd0);
        check("R10 addr held", rsp_addr, 32'h0000_8800);
        check("R10 epl held", 32'(rsp_epl), 32'd3);

        // R9: request sees pre-write table in the same cycle
        @(negedge clk);
        tr_load = 1'b1; tr_tbl = 2'd0; tr_base_in = 32'h2000_0000; tr_limit_in = 16'h00FF;
        req_valid = 1'b1; req_tbl = 2'd0; req_sel = 16'h0008; req_ar = 8'h92;
        @(negedge clk);
        tr_load = 1'b0; req_valid = 1'b0;
        check("R9 old base seen", rsp_addr, 32'h0001_0008);
        request(2'd0, 16'h0008, 8'h92, 2'd0);
        check("R9 new base seen", rsp_addr, 32'h2000_0008);

        // R8: reset in mid-run clears tables again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R8 rsp cleared", rsp_addr, 32'd0);
        read_back("R8 local cleared", 2'd1, 32'd0, 16'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule